// File: doc/BRIEF.md
# Serial Grant Chain Bus Arbiter

This block picks the next owner of a shared bus and hands it the right to drive the bus. Devices raise requests on five shared request classes: one class for direct memory access and four interrupt levels, numbered 4 to 7. A central arbiter turns the winning class into a grant. The grant then travels down a chain of per-device cells. Each cell either keeps the grant, when its own device wants that class, or hands it on to the next cell. The cell that keeps the grant answers with a selection acknowledge.

The selected device waits for two things before it takes bus ownership (bus busy): the present owner must release the bus, and the slave handshake line must be inactive. The arbiter can therefore choose the next owner while the present owner is still in the middle of a transfer. If a grant is not answered within a set number of clocks, the arbiter raises an error flag and starts again.

Requests are presented as a flat vector. Bit `d*5+c` is device `d`'s request for class `c`. Classes 0 to 3 are interrupt levels 4 to 7, and class 4 is direct memory access. Grant vectors use the same class order.

Top module: `bgc_top`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `arb_grant`, `chain_tail`, `sack`, `dev_master` and `grant_err` are all zero, and `bbsy` follows `ext_bbsy`.
- R2: The arbiter drives at most one grant bit at a time. A request on class 4 (direct memory access) wins over every interrupt level, whatever the value of `cpu_pri`.
- R3: Interrupt class c (level c+4) is granted only when c+4 > `cpu_pri`. Among the eligible levels, the highest one is granted.
- R4: A cell whose device has no request for the granted class passes the grant to the next cell in the same cycle. A grant that no device claims appears on `chain_tail`.
- R5: The first cell in the chain that requests the granted class blocks the grant from every later cell. It asserts `sack` one clock after the grant reaches it.
- R6: The arbiter removes its grant on the clock after it sees `sack`. It issues no new grant while `sack` is high.
- R7: A selected device takes bus ownership only on a clock where `ext_bbsy`, the ownership of every other device and `ssyn` are all low. On that same clock it drops `sack`, and it stops requesting while it holds the bus.
- R8: A new device can be granted and selected while another device holds the bus. At most one device holds the bus at any time.
- R9: If a grant goes unanswered for TMO_CYC clocks, the grant is removed and `grant_err` is set. `grant_err` stays set until reset, and the arbiter returns to idle so it can grant again.
- R10: A bus-owning device releases ownership on the clock after its `dev_done` bit is high. After that, its request becomes visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | NDEV*5 | Per-device class requests, bit d*5+c |
| dev_done | input | NDEV | Per-device end of ownership |
| stray_req | input | 5 | Requests from a device outside the chain that never answers |
| cpu_pri | input | 3 | Processor priority level |
| ext_bbsy | input | 1 | Bus owned by an agent outside the chain |
| ssyn | input | 1 | Slave handshake still active |
| arb_grant | output | 5 | Grant at the head of the chain |
| chain_tail | output | 5 | Grant leaving the last cell |
| sack | output | 1 | Wired-OR selection acknowledge |
| bbsy | output | 1 | Wired-OR bus busy |
| dev_master | output | NDEV | Device currently owning the bus |
| grant_err | output | 1 | Sticky unanswered-grant flag |

## Verification
The assertions check the following on every cycle: a single grant bit, the grant dropping after `sack`, no grant starting while `sack` is high, a cell claiming one clock after a grant, ownership taken only on an idle bus with `ssyn` low, release on done, a single bus owner, and a sticky error flag. Some behaviours can only be shown by the bench's scenarios. These are the level ordering against `cpu_pri`, which device wins inside the chain, a grant passing through to the tail, the exact timeout length and the retry after it, and a request staying hidden while its device owns the bus.

// File: rtl/bgc_pkg.sv
// Shared constants, state types and the class selection function for the
// serial grant chain arbiter. Class 0..3 are interrupt levels 4..7, class 4
// is direct memory access.
package bgc_pkg;
    localparam int NCLS    = 5;
    localparam int CLS_DMA = 4;

    typedef enum logic [1:0] {ARB_IDLE, ARB_GRANT, ARB_RELEASE} arb_st_t;
    typedef enum logic [1:0] {CELL_IDLE, CELL_SEL, CELL_MASTER} cell_st_t;

    // Pick one class: DMA first, then the highest interrupt level above pri.
    function automatic logic [NCLS-1:0] pick_class(input logic [NCLS-1:0] req,
                                                   input logic [2:0] pri);
        logic [NCLS-1:0] g;
        logic            found;
        g     = '0;
        found = 1'b0;
        if (req[CLS_DMA]) begin
            g[CLS_DMA] = 1'b1;
        end else begin
            for (int c = NCLS - 2; c >= 0; c--) begin
                if (!found && req[c] && ((c + 4) > int'(pri))) begin
                    g[c]  = 1'b1;
                    found = 1'b1;
                end
            end
        end
        return g;
    endfunction
endpackage

// File: rtl/bgc_arbiter.sv
// Central arbiter. Samples the wired-OR request lines, issues one grant,
// waits for the selection acknowledge or a timeout, then waits for the
// acknowledge to be released before granting again.
// Assumes TMO_CYC >= 2 and that only one cell can answer a grant.
module bgc_arbiter
    import bgc_pkg::*;
#(
    parameter int TMO_CYC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] req_line,
    input  logic [2:0]      cpu_pri,
    input  logic            sack_line,
    output logic [NCLS-1:0] grant_o,
    output logic            err_o
);
    localparam int CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;

    arb_st_t         st;
    logic [CW-1:0]   cnt;
    logic [NCLS-1:0] choice;

    // Candidate grant from the current requests and processor priority.
    always_comb choice = pick_class(req_line, cpu_pri);

    // Grant sequencing, timeout counting and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ARB_IDLE;
            grant_o <= '0;
            cnt     <= '0;
            err_o   <= 1'b0;
        end else begin
            case (st)
                ARB_IDLE: begin
                    if (!sack_line && (choice != '0)) begin
                        grant_o <= choice;
                        cnt     <= '0;
                        st      <= ARB_GRANT;
                    end
                end
                ARB_GRANT: begin
                    if (sack_line) begin
                        grant_o <= '0;
                        st      <= ARB_RELEASE;
                    end else if (cnt == CW'(TMO_CYC - 1)) begin
                        grant_o <= '0;
                        err_o   <= 1'b1;
                        st      <= ARB_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ARB_RELEASE: begin
                    if (!sack_line) st <= ARB_IDLE;
                end
                default: st <= ARB_IDLE;
            endcase
        end
    end

    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    a_r6_drop_on_sack: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != '0) && sack_line) |=> (grant_o == '0));
    a_r6_no_grant_during_sack: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(grant_o) == '0) && (grant_o != '0)) |-> !$past(sack_line));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: rtl/bgc_cell.sv
// Per-device grant chain cell. Passes a grant it does not want straight to
// the next cell, keeps one it wants and acknowledges it. It then takes the
// bus once the bus is idle and the slave handshake has ended.
// Assumes at most one grant class is active at a time.
module bgc_cell
    import bgc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] req_i,
    input  logic            done_i,
    input  logic            bus_bbsy,
    input  logic            ssyn,
    input  logic [NCLS-1:0] gin,
    output logic [NCLS-1:0] gout,
    output logic [NCLS-1:0] req_o,
    output logic            sack_o,
    output logic            bbsy_o
);
    cell_st_t        st;
    logic [NCLS-1:0] own_cls;
    logic [NCLS-1:0] block;

    // Grant blocking and request masking from the cell state.
    always_comb begin
        case (st)
            CELL_IDLE: block = req_i;
            CELL_SEL:  block = own_cls;
            default:   block = '0;
        endcase
        gout   = gin & ~block;
        req_o  = (st == CELL_MASTER) ? '0 : req_i;
        sack_o = (st == CELL_SEL);
        bbsy_o = (st == CELL_MASTER);
    end

    // Claim, bus takeover and release sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= CELL_IDLE;
            own_cls <= '0;
        end else begin
            case (st)
                CELL_IDLE: begin
                    if ((gin & req_i) != '0) begin
                        own_cls <= gin & req_i;
                        st      <= CELL_SEL;
                    end
                end
                CELL_SEL: begin
                    if (!bus_bbsy && !ssyn) st <= CELL_MASTER;
                end
                CELL_MASTER: begin
                    if (done_i) st <= CELL_IDLE;
                end
                default: st <= CELL_IDLE;
            endcase
        end
    end

    a_r5_claim_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == CELL_IDLE) && ((gin & req_i) != '0)) |=> sack_o);
    a_r7_take_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bbsy_o) |-> $past(!bus_bbsy && !ssyn));
    a_r10_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bbsy_o && done_i) |=> !bbsy_o);
endmodule

// File: rtl/bgc_top.sv
// Arbiter plus a chain of NDEV device cells. Grants run from the arbiter
// through cell 0 to cell NDEV-1. Request, acknowledge and busy lines are
// wired-OR across the cells. Assumes one synchronous clock domain.
module bgc_top
    import bgc_pkg::*;
#(
    parameter int NDEV    = 4,
    parameter int TMO_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NDEV*NCLS-1:0] dev_req,
    input  logic [NDEV-1:0]      dev_done,
    input  logic [NCLS-1:0]      stray_req,
    input  logic [2:0]           cpu_pri,
    input  logic                 ext_bbsy,
    input  logic                 ssyn,
    output logic [NCLS-1:0]      arb_grant,
    output logic [NCLS-1:0]      chain_tail,
    output logic                 sack,
    output logic                 bbsy,
    output logic [NDEV-1:0]      dev_master,
    output logic                 grant_err
);
    logic [NCLS-1:0] gchain   [NDEV+1];
    logic [NCLS-1:0] cell_req [NDEV];
    logic [NDEV-1:0] cell_sack;
    logic [NDEV-1:0] cell_bbsy;
    logic [NCLS-1:0] req_line;

    // Wired-OR of request, acknowledge and busy lines.
    always_comb begin
        req_line = stray_req;
        for (int d = 0; d < NDEV; d++) req_line = req_line | cell_req[d];
        sack = |cell_sack;
        bbsy = ext_bbsy | (|cell_bbsy);
    end

    assign gchain[0]  = arb_grant;
    assign chain_tail = gchain[NDEV];
    assign dev_master = cell_bbsy;

    bgc_arbiter #(.TMO_CYC(TMO_CYC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_line  (req_line),
        .cpu_pri   (cpu_pri),
        .sack_line (sack),
        .grant_o   (arb_grant),
        .err_o     (grant_err)
    );

    for (genvar d = 0; d < NDEV; d++) begin : g_cell
        bgc_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (dev_req[d*NCLS +: NCLS]),
            .done_i   (dev_done[d]),
            .bus_bbsy (bbsy),
            .ssyn     (ssyn),
            .gin      (gchain[d]),
            .gout     (gchain[d+1]),
            .req_o    (cell_req[d]),
            .sack_o   (cell_sack[d]),
            .bbsy_o   (cell_bbsy[d])
        );
    end

    a_r8_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cell_bbsy));
endmodule

// File: tb/tb_bgc_top.sv
`timescale 1ns/1ps
module tb_bgc_top;
    localparam int NDEV = 4;
    localparam int NC   = 5;
    localparam int TMO  = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NDEV*NC-1:0]   dev_req = '0;
    logic [NDEV-1:0]      dev_done = '0;
    logic [NC-1:0]        stray_req = '0;
    logic [2:0]           cpu_pri = '0;
    logic                 ext_bbsy = 1'b0;
    logic                 ssyn = 1'b0;
    logic [NC-1:0]        arb_grant, chain_tail;
    logic                 sack, bbsy, grant_err;
    logic [NDEV-1:0]      dev_master;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    bgc_top #(.NDEV(NDEV), .TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_done(dev_done),
        .stray_req(stray_req), .cpu_pri(cpu_pri), .ext_bbsy(ext_bbsy),
        .ssyn(ssyn), .arb_grant(arb_grant), .chain_tail(chain_tail),
        .sack(sack), .bbsy(bbsy), .dev_master(dev_master),
        .grant_err(grant_err)
    );

    // {dev_req, cpu_pri, expected grant, expected owner}
    localparam logic [31:0] VEC [8] = '{
        {20'h04000, 3'd7, 5'b10000, 4'b0100},
        {20'h80100, 3'd0, 5'b10000, 4'b1000},
        {20'h01001, 3'd3, 5'b00100, 4'b0100},
        {20'h01001, 3'd6, 5'b00000, 4'b0000},
        {20'h10040, 3'd4, 5'b00010, 4'b0010},
        {20'h00008, 3'd7, 5'b00000, 4'b0000},
        {20'h08000, 3'd3, 5'b00001, 4'b1000},
        {20'h00003, 3'd0, 5'b00010, 4'b0001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dev_req = '0; dev_done = '0; stray_req = '0;
        cpu_pri = '0; ext_bbsy = 1'b0; ssyn = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1 grant", 32'(arb_grant), 0);
        check("R1 sack/bbsy/owner", {30'(dev_master), sack, bbsy}, 0);
        check("R1 err", 32'(grant_err), 0);

        // R2 R3 R5 R6 R7: vector table walk
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            v = VEC[i];
            do_reset();
            ext_bbsy = 1'b1;
            dev_req  = v[31:12];
            cpu_pri  = v[11:9];
            @(negedge clk);
            check($sformatf("R2/R3 vec%0d grant", i), 32'(arb_grant), 32'(v[8:4]));
            check($sformatf("R5 vec%0d tail blocked", i), 32'(chain_tail), 0);
            @(negedge clk);
            check($sformatf("R5 vec%0d sack", i), 32'(sack), 32'(v[8:4] != 0));
            @(negedge clk);
            check($sformatf("R6 vec%0d grant dropped", i), 32'(arb_grant), 0);
            ext_bbsy = 1'b0;
            @(negedge clk);
            check($sformatf("R7 vec%0d owner", i), 32'(dev_master), 32'(v[3:0]));
        end

        // R4 R9: unanswered grant passes the chain and times out
        do_reset();
        stray_req = 5'b10000;
        dev_req   = 20'h00008;
        cpu_pri   = 3'd7;
        @(negedge clk);
        check("R4 tail pass", 32'(chain_tail), 32'b10000);
        repeat (7) @(negedge clk);
        check("R9 grant held", 32'(arb_grant), 32'b10000);
        check("R9 no err yet", 32'(grant_err), 0);
        @(negedge clk);
        check("R9 grant removed", 32'(arb_grant), 0);
        check("R9 err set", 32'(grant_err), 1);
        @(negedge clk);
        check("R9 regrant", 32'(arb_grant), 32'b10000);
        check("R9 err sticky", 32'(grant_err), 1);
        do_reset();
        @(negedge clk);
        check("R1 err cleared", 32'(grant_err), 0);

        // R7 R10: wait for ssyn, request masked, release on done
        do_reset();
        ext_bbsy = 1'b1;
        ssyn     = 1'b1;
        dev_req  = 20'h00200;
        repeat (3) @(negedge clk);
        ext_bbsy = 1'b0;
        @(negedge clk);
        check("R7 wait ssyn owner", 32'(dev_master), 0);
        check("R7 wait ssyn sack", 32'(sack), 1);
        ssyn = 1'b0;
        @(negedge clk);
        check("R7 took bus", 32'(dev_master), 32'b0010);
        check("R7 sack off", 32'(sack), 0);
        repeat (3) @(negedge clk);
        check("R7 request masked", 32'(arb_grant), 0);
        dev_done = 4'b0010;
        @(negedge clk);
        dev_done = '0;
        check("R10 released", 32'(bbsy), 0);
        @(negedge clk);
        check("R10 request back", 32'(arb_grant), 32'b10000);

        // R8: overlap of selection with an active owner
        do_reset();
        dev_req = 20'h00050;
        repeat (7) @(negedge clk);
        check("R8 owner during select", 32'(dev_master), 32'b0001);
        check("R8 next selected", 32'(sack), 1);
        check("R6 grant off", 32'(arb_grant), 0);
        dev_done = 4'b0001;
        dev_req  = 20'h00040;
        @(negedge clk);
        dev_done = '0;
        check("R10 owner released", 32'(dev_master), 0);
        check("R8 still waiting", 32'(sack), 1);
        @(negedge clk);
        check("R8 handover", 32'(dev_master), 32'b0010);
        check("R8 sack off", 32'(sack), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule